// File: doc/BRIEF.md
# Register-Mapped 16-bit Multiply-Accumulate Unit

This peripheral hangs on a plain word-wide register bus (byte address, write strobe, write data, read data). It forms the 32-bit product of two 16-bit operands, treated as either unsigned or two's-complement numbers, and can add each product into a running 32-bit sum. Software picks the mode implicitly. Four word addresses all load the first operand, and the address used decides the arithmetic. A store to the second-operand address then runs the operation at once, using the stored first operand.

The outcome is read back as a low word and a high word. A third word holds sign or carry information, depending on the mode. In the two plain-multiply modes the readback shows the last product. In the two accumulate modes it shows the running sum. The unit supports only 16-bit, word-aligned accesses. Read data is registered, so it follows the address by one clock.

Top module: `mac16_periph`

## Requirements
- R1: After synchronous reset both operands, the product register, the running sum and the carry flag are zero, and the unsigned-multiply mode is selected. Every register in the window then reads 0x0000.
- R2: A write of operand 1 selects the mode from the address used: 0x130 selects unsigned multiply (mode 0), 0x132 signed multiply (1), 0x134 unsigned accumulate (2) and 0x136 signed accumulate (3). The mode holds until the next operand-1 write. The low and high readback words come from the product register in modes 0 and 1, and from the running sum in modes 2 and 3.
- R3: A write of operand 2 at 0x138 performs the operation in the current mode with the stored operand 1 and the written value. The new outcome is returned by a read whose address is presented in the cycle after that write.
- R4: In unsigned multiply mode the 32-bit product of the two zero-extended operands is read as the low word at 0x13A and the high word at 0x13C.
- R5: In signed multiply mode both operands are sign-extended from bit 15 before multiplying, and 0x13A/0x13C return the 32-bit two's-complement product.
- R6: An operation in either plain-multiply mode clears the running sum to zero and clears the carry flag.
- R7: An operation in either accumulate mode adds the product (zero- or sign-extended per mode) to the running sum modulo 2^32. The product register is left unchanged.
- R8: The extension word at 0x13E reads 0x0000 in unsigned multiply mode. In signed multiply mode it reads 0xFFFF when bit 31 of the product register is set, and 0x0000 otherwise. In signed accumulate mode it does the same using bit 31 of the running sum.
- R9: In unsigned accumulate mode the extension word reads 0x0001 when the most recent unsigned accumulation carried out of bit 31, and 0x0000 otherwise. Operations in any other mode clear that flag.
- R10: Reads of 0x130 to 0x136 return operand 1, and a read of 0x138 returns operand 2. Reads of odd addresses or of addresses outside 0x130 to 0x13E return 0x0000. Writes to odd addresses, to the three readback addresses, or outside the window change nothing.
- R11: Read data is registered: bus_rdata shows the register selected by the address of the previous cycle, and reads 0x0000 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data for the previous cycle's address |

## Verification
The assertions assume that the bus keeps the write strobe at a known level from the first clock edge. They also assume that the configured window base is even, so that two register addresses never alias. The bench holds the strobe low through reset and only ever changes the address, data and strobe on falling edges. It uses the default base 0x130 throughout. It sweeps every pair from a set of edge-case operands (zero, one, the largest positive value, the most negative value, all ones and mixed patterns) through all four modes. In the accumulate modes the pairs are not cleared between steps, so the running sum wraps and the unsigned sweep produces carries.

// File: rtl/mac16_pkg.sv
`timescale 1ns/1ps
package mac16_pkg;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mac_mode_e;

  // word slots inside the register window; slots 0..3 load operand 1
  localparam int NUM_OP1   = 4;
  localparam int SLOT_OP2  = 4;
  localparam int SLOT_LO   = 5;
  localparam int SLOT_HI   = 6;
  localparam int SLOT_EXT  = 7;
  localparam int NUM_SLOTS = 8;

  function automatic logic mode_is_signed(mac_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_accum(mac_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/mac16_regs.sv
`timescale 1ns/1ps
module mac16_regs
  import mac16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_SLOTS-1:0] slot_hit,
  output logic [DATA_W-1:0]    op1_q,
  output logic [DATA_W-1:0]    op2_q,
  output mac_mode_e            mode_q,
  output logic                 start
);

  localparam int STRIDE = DATA_W / 8;

  // address compare per word slot; odd addresses never match an even base
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit[s] = (addr == BASE + ADDR_W'(s * STRIDE));
  end

  logic      op1_wr;
  mac_mode_e mode_n;

  assign op1_wr = wr && (|slot_hit[NUM_OP1-1:0]);
  assign start  = wr && slot_hit[SLOT_OP2];

  always_comb begin
    mode_n = mode_q;
    for (int k = 0; k < NUM_OP1; k++) begin
      if (slot_hit[k]) mode_n = mac_mode_e'(2'(k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= MODE_UMUL;
    end else begin
      if (op1_wr) begin
        op1_q  <= wdata;
        mode_q <= mode_n;
      end
      if (start) op2_q <= wdata;
    end
  end

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !op1_wr |=> $stable(mode_q));

  assert_op2_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr && slot_hit[SLOT_OP2]) |=> $stable(op2_q));

endmodule

// File: rtl/mac16_mult.sv
`timescale 1ns/1ps
module mac16_mult #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                sgn,
  output logic [2*DATA_W-1:0] prod
);

  localparam int PW = 2 * DATA_W;

  logic [PW-1:0] a_x, b_x;

  // extend to full product width; the low PW bits of the product are exact
  assign a_x = {{DATA_W{sgn & a[DATA_W-1]}}, a};
  assign b_x = {{DATA_W{sgn & b[DATA_W-1]}}, b};
  assign prod = a_x * b_x;

endmodule

// File: rtl/mac16_accum.sv
`timescale 1ns/1ps
module mac16_accum
  import mac16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  mac_mode_e           mode,
  input  logic [2*DATA_W-1:0] prod,
  output logic [2*DATA_W-1:0] res_q,
  output logic [2*DATA_W-1:0] acc_q,
  output logic                carry_q
);

  localparam int PW = 2 * DATA_W;

  logic [PW:0] sum_w;

  assign sum_w = {1'b0, acc_q} + {1'b0, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (start) begin
      if (mode_is_accum(mode)) begin
        acc_q   <= sum_w[PW-1:0];
        carry_q <= (mode == MODE_UMAC) && sum_w[PW];
      end else begin
        res_q   <= prod;
        acc_q   <= '0;
        carry_q <= 1'b0;
      end
    end
  end

  assert_mul_clears_acc_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !mode_is_accum(mode)) |=> (acc_q == '0) && !carry_q);

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(acc_q) && $stable(res_q) && $stable(carry_q));

  assert_mac_keeps_res_R7: assert property (@(posedge clk) disable iff (rst)
    (start && mode_is_accum(mode)) |=> $stable(res_q));

  assert_carry_umac_only_R9: assert property (@(posedge clk) disable iff (rst)
    (start && mode != MODE_UMAC) |=> !carry_q);

  assert_mul_result_R3: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_UMUL) |=> res_q == $past(prod));

endmodule

// File: rtl/mac16_rdmux.sv
`timescale 1ns/1ps
module mac16_rdmux
  import mac16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] slot_hit,
  input  mac_mode_e            mode,
  input  logic [DATA_W-1:0]    op1,
  input  logic [DATA_W-1:0]    op2,
  input  logic [2*DATA_W-1:0]  res,
  input  logic [2*DATA_W-1:0]  acc,
  input  logic                 carry,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int PW = 2 * DATA_W;

  logic [PW-1:0]     shown;
  logic [DATA_W-1:0] ext_w;
  logic [DATA_W-1:0] rd_n;

  assign shown = mode_is_accum(mode) ? acc : res;

  always_comb begin
    unique case (mode)
      MODE_UMUL: ext_w = '0;
      MODE_SMUL: ext_w = {DATA_W{res[PW-1]}};
      MODE_UMAC: ext_w = DATA_W'(carry);
      MODE_SMAC: ext_w = {DATA_W{acc[PW-1]}};
      default:   ext_w = '0;
    endcase
  end

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < NUM_OP1; k++) begin
      if (slot_hit[k]) rd_n = op1;
    end
    if (slot_hit[SLOT_OP2]) rd_n = op2;
    if (slot_hit[SLOT_LO])  rd_n = shown[DATA_W-1:0];
    if (slot_hit[SLOT_HI])  rd_n = shown[PW-1:DATA_W];
    if (slot_hit[SLOT_EXT]) rd_n = ext_w;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  assert_outside_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !(|slot_hit) |=> rd_data == '0);

  assert_ext_umul_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (slot_hit[SLOT_EXT] && mode == MODE_UMUL) |=> rd_data == '0);

  assert_ext_umac_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (slot_hit[SLOT_EXT] && mode == MODE_UMAC) |=> rd_data[DATA_W-1:1] == '0);

endmodule

// File: rtl/mac16_periph.sv
`timescale 1ns/1ps
module mac16_periph
  import mac16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PW = 2 * DATA_W;

  logic [NUM_SLOTS-1:0] slot_hit;
  logic [DATA_W-1:0]    op1_q, op2_q;
  mac_mode_e            mode_q;
  logic                 start;
  logic [PW-1:0]        prod, res_q, acc_q;
  logic                 carry_q;

  mac16_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .slot_hit(slot_hit), .op1_q(op1_q), .op2_q(op2_q), .mode_q(mode_q),
    .start(start)
  );

  // operand 2 enters straight from the bus in the cycle of its write
  mac16_mult #(.DATA_W(DATA_W)) u_mult (
    .a(op1_q), .b(bus_wdata), .sgn(mode_is_signed(mode_q)), .prod(prod)
  );

  mac16_accum #(.DATA_W(DATA_W)) u_accum (
    .clk(clk), .rst(rst), .start(start), .mode(mode_q), .prod(prod),
    .res_q(res_q), .acc_q(acc_q), .carry_q(carry_q)
  );

  mac16_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst(rst), .slot_hit(slot_hit), .mode(mode_q),
    .op1(op1_q), .op2(op2_q), .res(res_q), .acc(acc_q), .carry(carry_q),
    .rd_data(bus_rdata)
  );

  assert_reset_read_R11: assert property (@(posedge clk)
    rst |=> bus_rdata == '0);

endmodule

// File: tb/sim_mac16_periph.sv
`timescale 1ns/1ps
module sim_mac16_periph;

  localparam logic [15:0] BASE = 16'h0130;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac16_periph u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata)
  );

  // reference model state
  logic [1:0]  m_mode = 2'd0;
  logic [15:0] m_op1 = '0, m_op2 = '0;
  logic [31:0] m_res = '0, m_acc = '0;
  logic        m_carry = 1'b0;

  logic [15:0] vals [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                             16'h8001, 16'hFFFF, 16'h1234, 16'hC3A5, 16'hFFFE};

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // both tasks are entered and left on a falling edge
  task automatic bwr(input logic [15:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [15:0] a, output logic [15:0] v);
    addr = a; wr = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic op1w(input logic [1:0] m, input logic [15:0] v);
    bwr(BASE + 16'(2 * m), v);
    m_mode = m;
    m_op1 = v;
  endtask

  task automatic op2w(input logic [15:0] v);
    longint pa, pb, prod;
    logic [32:0] sum;
    bwr(BASE + 16'h8, v);
    m_op2 = v;
    pa = m_mode[0] ? longint'($signed(m_op1)) : longint'(m_op1);
    pb = m_mode[0] ? longint'($signed(v)) : longint'(v);
    prod = pa * pb;
    if (m_mode[1]) begin
      sum = {1'b0, m_acc} + {1'b0, prod[31:0]};
      m_acc = sum[31:0];
      m_carry = (m_mode == 2'd2) && sum[32];
    end else begin
      m_res = prod[31:0];
      m_acc = '0;
      m_carry = 1'b0;
    end
  endtask

  task automatic chk_out(input string tag_lh, input string tag_ext);
    logic [15:0] v;
    logic [31:0] shown;
    logic [15:0] ext;
    shown = m_mode[1] ? m_acc : m_res;
    case (m_mode)
      2'd0: ext = 16'h0000;
      2'd1: ext = m_res[31] ? 16'hFFFF : 16'h0000;
      2'd2: ext = {15'b0, m_carry};
      default: ext = m_acc[31] ? 16'hFFFF : 16'h0000;
    endcase
    brd(BASE + 16'hA, v); check({tag_lh, " low"}, v, shown[15:0]);
    brd(BASE + 16'hC, v); check({tag_lh, " high"}, v, shown[31:16]);
    brd(BASE + 16'hE, v); check(tag_ext, v, ext);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R11 rdata in reset", rdata, 16'h0000);
    rst = 1'b0;
    // R1: every window register reads zero after reset
    for (int k = 0; k < 8; k++) begin
      brd(BASE + 16'(2 * k), v);
      check("R1 reset read", v, 16'h0000);
    end

    // R4/R5/R7 with R8/R9 extension, all four modes, all operand pairs
    for (int m = 0; m < 4; m++) begin
      if (m >= 2) begin
        op1w(2'd0, 16'h0003); op2w(16'h0005);
        op1w(2'(m), 16'h0000);
        chk_out("R6 sum cleared by multiply", "R6 ext after clear");
      end
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          op1w(2'(m), vals[i]);
          op2w(vals[j]);
          case (m)
            0: chk_out("R3 R4 unsigned product", "R8 unsigned ext");
            1: chk_out("R3 R5 signed product", "R8 signed ext");
            2: chk_out("R7 unsigned sum", "R9 carry ext");
            default: chk_out("R7 signed sum", "R8 signed sum ext");
          endcase
        end
      end
    end

    // R2: switching mode without operand 2 changes what is shown
    op1w(2'd1, 16'h8000); op2w(16'h0002);
    op1w(2'd3, 16'h0001); op2w(16'hFFFF);
    op1w(2'd1, 16'h0000);
    chk_out("R2 back to product view", "R2 ext product view");
    op1w(2'd3, 16'h0000);
    chk_out("R2 sum view", "R2 ext sum view");
    op1w(2'd0, 16'h0000);
    chk_out("R2 unsigned view", "R2 ext unsigned view");

    // R10: operand readback and ignored accesses
    op1w(2'd0, 16'h5A5A); op2w(16'h0102);
    for (int k = 0; k < 4; k++) begin
      brd(BASE + 16'(2 * k), v);
      check("R10 op1 readback", v, 16'h5A5A);
    end
    brd(BASE + 16'h8, v); check("R10 op2 readback", v, 16'h0102);
    bwr(16'h0131, 16'hFFFF);
    bwr(16'h0133, 16'hFFFF);
    bwr(16'h0140, 16'hFFFF);
    bwr(16'h012E, 16'hFFFF);
    bwr(BASE + 16'hA, 16'hFFFF);
    bwr(BASE + 16'hC, 16'hFFFF);
    bwr(BASE + 16'hE, 16'hFFFF);
    brd(BASE, v); check("R10 op1 after ignored writes", v, 16'h5A5A);
    brd(BASE + 16'h8, v); check("R10 op2 after ignored writes", v, 16'h0102);
    chk_out("R10 result after ignored writes", "R10 ext after ignored writes");
    brd(16'h0131, v); check("R10 odd address read", v, 16'h0000);
    brd(16'h0140, v); check("R10 above window read", v, 16'h0000);
    brd(16'h012E, v); check("R10 below window read", v, 16'h0000);

    // R11: data follows the address of the previous cycle
    addr = BASE + 16'hA;
    @(negedge clk);
    addr = BASE + 16'h8;
    check("R11 registered read", rdata, m_res[15:0]);
    @(negedge clk);
    check("R11 registered read next", rdata, 16'h0102);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule